// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block computes the byte address of every element of one DMA work unit. Software loads a start address, an element count per row, a row count and two signed byte strides, then sets the enable bit. From then on, each element-done strobe from the bus master moves the current address on by one stride. The block also counts down the element and row counters and reports when a row ends and when the whole work unit is complete. When the work unit completes, the channel disables itself.

In one-dimensional mode the element stride is applied after every element, and the row count is ignored. In two-dimensional mode the element stride is applied inside a row. At the last element of each row the row stride is used instead and the element counter reloads. There is one exception: the very last transfer of the work unit always uses the element stride. A stride of zero is legal and keeps the address fixed, which suits a memory-mapped peripheral register.

Top module: `dma2d_agen`

## Requirements
- R1: After reset the channel is disabled (`busy` = 0), `cur_addr` is 0, `row_end` and `unit_done` are 0, and register 0 reads 0.
- R2: Writing register 0 with bit 0 set while disabled starts a session. On the next cycle `cur_addr` equals register 1 and register 7 reads {rows, elements}: the row count comes from register 3 if bit 1 of that write was set, and is 1 otherwise.
- R3: In one-dimensional mode (register 0 bit 1 = 0) every strobe adds the element stride from register 4 to `cur_addr`. The strobe numbered by register 2 raises `unit_done` for one cycle and clears `busy`.
- R4: In two-dimensional mode the element stride is added within a row. The last element of any row except the final one adds the row stride from register 5, reloads the element counter, decrements the row counter and pulses `row_end`.
- R5: The final transfer of a work unit adds the element stride, never the row stride. In two-dimensional mode it pulses `row_end` and `unit_done` together, and it clears `busy`.
- R6: Both strides are signed two's-complement byte amounts added modulo 2^AW. Negative strides move the address down, and a zero stride leaves it unchanged.
- R7: Strobes on `elem_done` while disabled change neither the address, the counters nor the pulse outputs.
- R8: Register 7 (bits 15:0 elements left, bits 31:16 rows left) can be written while disabled. A write to it while enabled is ignored.
- R9: Registers 1 to 5 (start, element count, row count, element stride, row stride) read back what was written. Register 6 reads `cur_addr`, and register 0 reads {mode at bit 1, enable at bit 0}.
- R10: Writing register 0 with bit 0 clear while enabled stops the channel. Later strobes are then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data, combinational on `reg_addr` |
| elem_done | input | 1 | One element has been transferred |
| cur_addr | output | AW | Address of the next element |
| busy | output | 1 | Channel enabled |
| row_end | output | 1 | One-cycle pulse after the last element of a row |
| unit_done | output | 1 | One-cycle pulse after the last element of the work unit |

## Verification
The end of a row and the end of the work unit coincide on the last element of the final row. The same strobe must then raise both pulses, clear the enable bit and pick the element stride instead of the row stride. Table rows with one, two and three rows, with positive, negative and zero strides, all end in this cycle. A per-strobe model checks the address, both pulses and `busy` on the cycle after each strobe. Single-row two-dimensional and single-element one-dimensional units provoke the case in which the first row is also the last.

// File: rtl/dma2d_pkg.sv
// Shared types for the DMA address generator: register selects and step kinds.
package dma2d_pkg;

    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_START = 3'd1,
        REG_ICNT  = 3'd2,
        REG_OCNT  = 3'd3,
        REG_ISTR  = 3'd4,
        REG_OSTR  = 3'd5,
        REG_CADDR = 3'd6,
        REG_CCNT  = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        STEP_NONE  = 2'd0,
        STEP_INNER = 2'd1,
        STEP_OUTER = 2'd2
    } step_e;

endpackage

// File: rtl/dma2d_regs.sv
// Configuration registers and enable control.
// Holds start address, counts and strides, plus enable and mode bits.
// Assumes one register access per cycle; mode changes only while disabled.
module dma2d_regs
    import dma2d_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    input  logic          finish,
    output logic          en,
    output logic          mode2d,
    output logic          start,
    output logic          start_2d,
    output logic [AW-1:0] start_addr,
    output logic [CW-1:0] icnt,
    output logic [CW-1:0] ocnt,
    output logic [AW-1:0] istr,
    output logic [AW-1:0] ostr
);

    logic ctrl_we;

    // Decode a control write and a session start.
    always_comb begin
        ctrl_we  = reg_we && (reg_addr == REG_CTRL);
        start    = ctrl_we && reg_wdata[0] && !en;
        start_2d = reg_wdata[1];
    end

    // Enable and mode: completion wins, then software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= 1'b0;
            mode2d <= 1'b0;
        end else if (finish) begin
            en <= 1'b0;
        end else if (ctrl_we) begin
            en <= reg_wdata[0];
            if (!en) mode2d <= reg_wdata[1];
        end
    end

    // Plain configuration registers, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_addr <= '0;
            icnt       <= '0;
            ocnt       <= '0;
            istr       <= '0;
            ostr       <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                REG_START: start_addr <= reg_wdata;
                REG_ICNT:  icnt       <= reg_wdata[CW-1:0];
                REG_OCNT:  ocnt       <= reg_wdata[CW-1:0];
                REG_ISTR:  istr       <= reg_wdata;
                REG_OSTR:  ostr       <= reg_wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dma2d_walk.sv
// Element and row counters.
// Picks which stride each strobe applies and raises the row-end and done pulses.
// Assumes programmed counts of at least 1; a count of 0 behaves as 1.
module dma2d_walk
    import dma2d_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_2d,
    input  logic          en,
    input  logic          mode2d,
    input  logic          strobe,
    input  logic [CW-1:0] icnt,
    input  logic [CW-1:0] ocnt,
    input  logic          cnt_we,
    input  logic [2*CW-1:0] cnt_wdata,
    output logic [CW-1:0] cur_in,
    output logic [CW-1:0] cur_out,
    output step_e         step,
    output logic          finish,
    output logic          row_end,
    output logic          unit_done
);

    logic active, last_in, last_row;

    // Classify the current strobe: within a row, at row end, or at unit end.
    always_comb begin
        active   = en && strobe;
        last_in  = (cur_in <= CW'(1));
        last_row = !mode2d || (cur_out <= CW'(1));
        step     = STEP_NONE;
        finish   = 1'b0;
        if (active) begin
            if (last_in && last_row) begin
                step   = STEP_INNER;
                finish = 1'b1;
            end else if (last_in) begin
                step = STEP_OUTER;
            end else begin
                step = STEP_INNER;
            end
        end
    end

    // Counter update: session load, software write while idle, or step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_in  <= '0;
            cur_out <= '0;
        end else if (start) begin
            cur_in  <= icnt;
            cur_out <= start_2d ? ocnt : CW'(1);
        end else if (cnt_we && !en) begin
            cur_in  <= cnt_wdata[CW-1:0];
            cur_out <= cnt_wdata[2*CW-1:CW];
        end else if (active) begin
            if (step == STEP_OUTER) begin
                cur_in  <= icnt;
                cur_out <= cur_out - CW'(1);
            end else begin
                cur_in <= cur_in - CW'(1);
                if (finish) cur_out <= cur_out - CW'(1);
            end
        end
    end

    // Registered one-cycle event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_end   <= 1'b0;
            unit_done <= 1'b0;
        end else begin
            row_end   <= active && last_in && mode2d;
            unit_done <= finish;
        end
    end

endmodule

// File: rtl/dma2d_addr.sv
// Current address accumulator.
// Loads the start address and adds the selected signed stride.
// Assumes strides are two's-complement byte amounts; the sum wraps modulo 2^AW.
module dma2d_addr
    import dma2d_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  step_e         step,
    input  logic [AW-1:0] istr,
    input  logic [AW-1:0] ostr,
    output logic [AW-1:0] cur_addr
);

    logic [AW-1:0] delta;

    // Select the stride for this cycle.
    always_comb begin
        case (step)
            STEP_INNER: delta = istr;
            STEP_OUTER: delta = ostr;
            default:    delta = '0;
        endcase
    end

    // Address register: load at session start, else accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n)     cur_addr <= '0;
        else if (start) cur_addr <= start_addr;
        else            cur_addr <= cur_addr + delta;
    end

endmodule

// File: rtl/dma2d_agen.sv
// Top of the DMA address generator.
// Joins registers, counters and address path, and muxes register reads.
// Assumes AW >= 2*CW so the packed counter register fits in one word.
module dma2d_agen
    import dma2d_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic          elem_done,
    output logic [AW-1:0] cur_addr,
    output logic          busy,
    output logic          row_end,
    output logic          unit_done
);

    logic          en, mode2d, start, start_2d, finish, cnt_we;
    logic [AW-1:0] start_addr, istr, ostr;
    logic [CW-1:0] icnt, ocnt, cur_in, cur_out;
    step_e         step;

    // Write strobe for the current-count register.
    always_comb begin
        cnt_we = reg_we && (reg_addr == REG_CCNT);
        busy   = en;
    end

    dma2d_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .finish(finish), .en(en), .mode2d(mode2d),
        .start(start), .start_2d(start_2d), .start_addr(start_addr),
        .icnt(icnt), .ocnt(ocnt), .istr(istr), .ostr(ostr)
    );

    dma2d_walk #(.CW(CW)) u_walk (
        .clk(clk), .rst_n(rst_n), .start(start), .start_2d(start_2d),
        .en(en), .mode2d(mode2d), .strobe(elem_done), .icnt(icnt),
        .ocnt(ocnt), .cnt_we(cnt_we), .cnt_wdata(reg_wdata[2*CW-1:0]),
        .cur_in(cur_in), .cur_out(cur_out), .step(step), .finish(finish),
        .row_end(row_end), .unit_done(unit_done)
    );

    dma2d_addr #(.AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .step(step), .istr(istr), .ostr(ostr), .cur_addr(cur_addr)
    );

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CTRL:  reg_rdata = AW'({mode2d, en});
            REG_START: reg_rdata = start_addr;
            REG_ICNT:  reg_rdata = AW'(icnt);
            REG_OCNT:  reg_rdata = AW'(ocnt);
            REG_ISTR:  reg_rdata = istr;
            REG_OSTR:  reg_rdata = ostr;
            REG_CADDR: reg_rdata = cur_addr;
            REG_CCNT:  reg_rdata = AW'({cur_out, cur_in});
            default: ;
        endcase
    end

endmodule

// File: rtl/dma2d_agen_chk.sv
// Temporal checks on the address generator, bound to the top.
// Assumes synchronous active-low reset.
module dma2d_agen_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          elem_done,
    input logic          reg_we,
    input logic          start,
    input logic [AW-1:0] start_addr,
    input logic [AW-1:0] cur_addr,
    input logic          row_end,
    input logic          unit_done,
    input logic          mode2d,
    input logic [CW-1:0] cur_in,
    input logic [CW-1:0] cur_out
);

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start) |-> cur_addr == $past(start_addr)); // R2
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        unit_done |-> !busy); // R3
    AST_ROW_ONLY_2D: assert property (@(posedge clk) disable iff (!rst_n)
        row_end |-> $past(mode2d)); // R4
    AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        unit_done |=> !unit_done); // R5
    AST_IDLE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!busy && !reg_we) |-> $stable(cur_addr)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!busy) |-> (!row_end && !unit_done)); // R7
    AST_CNT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy && !elem_done) |-> $stable({cur_out, cur_in})); // R8

endmodule

bind dma2d_agen dma2d_agen_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .elem_done(elem_done),
    .reg_we(reg_we), .start(start), .start_addr(start_addr),
    .cur_addr(cur_addr), .row_end(row_end), .unit_done(unit_done),
    .mode2d(mode2d), .cur_in(cur_in), .cur_out(cur_out)
);

// File: tb/dma2d_agen_tb.sv
// Bench: table-driven work units, then directed reset and corner cases.
module dma2d_agen_tb_top;

    localparam int AW = 32;
    localparam int CW = 16;

    typedef struct packed {
        logic          m2d;
        logic [31:0]   sa;
        logic [15:0]   ic;
        logic [15:0]   oc;
        logic [31:0]   is;
        logic [31:0]   os;
        logic [31:0]   fin;
        logic [7:0]    rows;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 32'h1000, 16'd4, 16'd9, 32'h4,        32'h77,       32'h1010, 8'd0},
        '{1'b1, 32'h2000, 16'd3, 16'd2, 32'h2,        32'h10,       32'h201A, 8'd2},
        '{1'b1, 32'h3000, 16'd2, 16'd3, 32'hFFFFFFFC, 32'hFFFFFFE0, 32'h2FB0, 8'd3},
        '{1'b1, 32'h4000, 16'd2, 16'd2, 32'h0,        32'h0,        32'h4000, 8'd2},
        '{1'b0, 32'h5000, 16'd1, 16'd1, 32'h8,        32'h40,       32'h5008, 8'd0},
        '{1'b1, 32'h6000, 16'd3, 16'd1, 32'h1,        32'h100,      32'h6003, 8'd1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          elem_done = 1'b0;
    logic [AW-1:0] cur_addr;
    logic          busy, row_end, unit_done;

    int total = 0;
    int bad = 0;
    bit ended = 0;

    always #10 clk = ~clk;

    dma2d_agen #(.AW(AW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .elem_done(elem_done),
        .cur_addr(cur_addr), .busy(busy), .row_end(row_end), .unit_done(unit_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic strobe();
        @(negedge clk);
        elem_done = 1'b1;
        @(negedge clk);
        elem_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d, ea;
        int ci, co, nrow;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 cur_addr", cur_addr, 32'd0);
        check("R1 pulses", {30'd0, row_end, unit_done}, 32'd0);
        rd(3'd0, d); check("R1 ctrl", d, 32'd0);

        // Table walk: R2..R6
        for (int v = 0; v < NV; v++) begin
            wr(3'd1, TBL[v].sa); wr(3'd2, {16'd0, TBL[v].ic});
            wr(3'd3, {16'd0, TBL[v].oc}); wr(3'd4, TBL[v].is); wr(3'd5, TBL[v].os);
            wr(3'd0, {30'd0, TBL[v].m2d, 1'b1});
            check("R2 load addr", cur_addr, TBL[v].sa);
            ci = TBL[v].ic; co = TBL[v].m2d ? TBL[v].oc : 1;
            rd(3'd7, d); check("R2 load counts", d, {co[15:0], ci[15:0]});
            check("R2 busy", {31'd0, busy}, 32'd1);
            ea = TBL[v].sa; nrow = 0;
            for (int s = 0; s < 64; s++) begin
                logic fin_e, row_e;
                fin_e = (ci == 1) && (!TBL[v].m2d || co == 1);
                row_e = (ci == 1) && TBL[v].m2d;
                if (fin_e)        begin ea = ea + TBL[v].is; end
                else if (ci == 1) begin ea = ea + TBL[v].os; ci = TBL[v].ic; co--; end
                else              begin ea = ea + TBL[v].is; ci--; end
                strobe();
                if (row_e) nrow++;
                check(TBL[v].m2d ? "R4 addr step" : "R3 addr step", cur_addr, ea);
                check("R4 row_end", {31'd0, row_end}, {31'd0, row_e});
                check("R5 unit_done", {31'd0, unit_done}, {31'd0, fin_e});
                if (fin_e) break;
            end
            check("R5 busy cleared", {31'd0, busy}, 32'd0);
            check("R6 final addr", cur_addr, TBL[v].fin);
            check("R4 rows seen", nrow, {24'd0, TBL[v].rows});
            rd(3'd6, d); check("R9 caddr read", d, TBL[v].fin);
        end

        // R9 config readback
        wr(3'd4, 32'hDEADBEEC);
        rd(3'd4, d); check("R9 istr", d, 32'hDEADBEEC);
        rd(3'd1, d); check("R9 start", d, 32'h6000);
        rd(3'd3, d); check("R9 ocnt", d, 32'd1);
        rd(3'd0, d); check("R9 ctrl", d, 32'd2);

        // R7 strobe while disabled
        strobe();
        check("R7 addr held", cur_addr, 32'h6003);
        check("R7 no pulse", {30'd0, row_end, unit_done}, 32'd0);
        rd(3'd7, d); check("R7 counts held", d, 32'h0000_0000);

        // R8 current counts writable only while disabled
        wr(3'd7, 32'h0005_0007);
        rd(3'd7, d); check("R8 idle write", d, 32'h0005_0007);
        wr(3'd1, 32'h8000); wr(3'd2, 32'd5); wr(3'd4, 32'd4);
        wr(3'd0, 32'h1);
        wr(3'd7, 32'h0001_0001);
        rd(3'd7, d); check("R8 busy write ignored", d, 32'h0001_0005);

        // R10 abort then ignored strobes
        strobe(); strobe();
        check("R10 pre-abort addr", cur_addr, 32'h8008);
        wr(3'd0, 32'h0);
        check("R10 stopped", {31'd0, busy}, 32'd0);
        strobe();
        check("R10 addr held", cur_addr, 32'h8008);
        check("R10 no done", {31'd0, unit_done}, 32'd0);

        finish_run();
    end

endmodule